// File: doc/BRIEF.md
# Timed-Edge Signal Boundary Converters

This block sits at the edge between ordinary one-bit logic and a timing-encoded signal domain. In the encoded domain, every cycle of a fixed grid clock carries one word: the signal level at the start of the cycle, an edge count from zero to two, and two W-bit sub-cycle offsets held in ascending order. Each edge toggles the level, so the level at the end of the cycle is the start level XOR the parity of the edge count. The offset width W sets the timing resolution: one grid cycle spans 2^W offset steps.

The input converter takes a plain bit on a valid/ready stream and emits one encoded word per accepted bit. A change against the remembered previous value becomes a single edge at offset zero. An unchanged value becomes a steady word with no edges. Back-pressure passes straight through: `in_ready` follows `eo_ready`, `eo_valid` follows `in_valid`, and the remembered value moves only on a completed handshake. A stalled word therefore stays unchanged until it is taken.

The output converter takes encoded words. When enabled by parameter, it first removes any pair of edges closer together than `MINW` offset steps, including zero-width pairs, and it presents the filtered word. It then resolves the final level of the cycle onto `out_bit`. The `SAMPLE` parameter picks when that happens: in the same cycle (offset zero), at the falling grid edge of that cycle, or at the next rising grid edge. Both converters give their result in the same grid cycle as their input.

Top module: `ted_boundary`

## Requirements
- R1: After reset the remembered input value and the held output level are low: with `in_bit`=0 the encoder emits start=0 and count=0, and `out_bit` is 0 in every sample mode.
- R2: An accepted `in_bit` that differs from the remembered value gives `eo_cnt`=1 with `eo_off0`=0 and `eo_off1`=0, and `eo_start` equal to the remembered value.
- R3: An accepted `in_bit` equal to the remembered value gives `eo_cnt`=0 and offsets 0, with `eo_start` equal to that value (steady high or steady low).
- R4: `in_ready` equals `eo_ready` and `eo_valid` equals `in_valid` in the same cycle; the remembered value updates only when `in_valid` and `eo_ready` are both high, so a stalled word repeats unchanged.
- R5: With the filter enabled, an input word with `ei_cnt`=2 and `ei_off1`-`ei_off0` < `MINW` (unsigned W-bit difference, zero included) leaves with `ef_cnt`=0; start and offsets pass unchanged.
- R6: Words with `ei_cnt` of 0 or 1, and pairs with a difference of at least `MINW`, pass the filter with the count unchanged; `ef_start`, `ef_off0` and `ef_off1` always equal the inputs.
- R7: The resolved final level is `ei_start` XOR bit 0 of the filtered count; a removed pair therefore leaves the level carried into the next cycle unchanged.
- R8: With `SAMPLE`=0, `out_bit` shows the final level of a valid word in the same cycle, and shows the held level while `ei_valid` is low.
- R9: With `SAMPLE`=1, `out_bit` takes the same value as mode 0 at the falling clock edge in the middle of that cycle.
- R10: With `SAMPLE`=2, `out_bit` shows the final level of the last valid word from the rising edge that ends its cycle.
- R11: While `ei_valid` is low, the held output level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grid clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_bit | input | 1 | Plain input bit |
| in_valid | input | 1 | Plain input is offered |
| in_ready | output | 1 | Plain input is taken this cycle |
| eo_valid | output | 1 | Encoded output word is valid |
| eo_ready | input | 1 | Downstream takes the encoded word |
| eo_start | output | 1 | Encoded output: level at cycle start |
| eo_cnt | output | 2 | Encoded output: edge count |
| eo_off0 | output | W | Encoded output: first edge offset |
| eo_off1 | output | W | Encoded output: second edge offset |
| ei_valid | input | 1 | Encoded input word is valid |
| ei_start | input | 1 | Encoded input: level at cycle start |
| ei_cnt | input | 2 | Encoded input: edge count |
| ei_off0 | input | W | Encoded input: first edge offset |
| ei_off1 | input | W | Encoded input: second edge offset |
| ef_start | output | 1 | Filtered word: start level |
| ef_cnt | output | 2 | Filtered word: edge count |
| ef_off0 | output | W | Filtered word: first offset |
| ef_off1 | output | W | Filtered word: second offset |
| out_bit | output | 1 | Resolved plain output bit |

## Verification
Pulse removal and output resolution can fall in the same cycle. A narrow pair then changes the edge count the resolver sees, while a wide pair leaves it alone. The random stimulus produces two-edge words with offset gaps on both sides of `MINW`, and also zero gaps, mixed with odd counts and idle cycles. In the same cycle the bench judges both the filtered count and the resolved level against its own model, in all three sample modes at once. Separate directed cases drive the input stream with `eo_ready` held low and then released, to show that a stalled word repeats and that the remembered value moves only on a handshake.

// File: rtl/ted_pkg.sv
package ted_pkg;
  typedef logic [1:0] edge_cnt_t;

  localparam edge_cnt_t CNT_NONE = 2'd0;
  localparam edge_cnt_t CNT_ONE  = 2'd1;
  localparam edge_cnt_t CNT_TWO  = 2'd2;

  localparam int SAMPLE_NOW  = 0;
  localparam int SAMPLE_FALL = 1;
  localparam int SAMPLE_RISE = 2;

  function automatic logic final_level(input logic start, input edge_cnt_t cnt);
    return start ^ cnt[0];
  endfunction
endpackage

// File: rtl/ted_in_conv.sv
module ted_in_conv
  import ted_pkg::*;
#(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_bit,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          eo_valid,
  input  logic          eo_ready,
  output logic          eo_start,
  output edge_cnt_t     eo_cnt,
  output logic [W-1:0]  eo_off0,
  output logic [W-1:0]  eo_off1
);
  logic prev_q;
  logic take;

  assign in_ready = eo_ready;
  assign eo_valid = in_valid;
  assign take     = in_valid && eo_ready;

  always_comb begin
    eo_start = prev_q;
    eo_off0  = '0;
    eo_off1  = '0;
    eo_cnt   = (in_bit != prev_q) ? CNT_ONE : CNT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else if (take) prev_q <= in_bit;
  end

  // R4: the remembered value moves only on a handshake
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(eo_start));
  // R2: after a handshake the next start level is the bit that was taken
  a_r2_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> eo_start == $past(in_bit));
  // R3: a word without edges keeps the start level equal to the input
  a_r3_steady_code: assert property (@(posedge clk) disable iff (!rst_n)
    (eo_cnt == CNT_NONE) |-> (eo_start == in_bit));
endmodule

// File: rtl/ted_pulse_filter.sv
module ted_pulse_filter
  import ted_pkg::*;
#(
  parameter int W    = 4,
  parameter int MINW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_start,
  input  edge_cnt_t     i_cnt,
  input  logic [W-1:0]  i_off0,
  input  logic [W-1:0]  i_off1,
  output logic          o_start,
  output edge_cnt_t     o_cnt,
  output logic [W-1:0]  o_off0,
  output logic [W-1:0]  o_off1
);
  localparam int DW = W + 1;
  localparam logic [DW-1:0] MINV = DW'(MINW);

  logic [W-1:0] gap;
  logic         narrow;

  assign gap    = i_off1 - i_off0;
  assign narrow = (i_cnt == CNT_TWO) && ({1'b0, gap} < MINV);

  always_comb begin
    o_start = i_start;
    o_off0  = i_off0;
    o_off1  = i_off1;
    o_cnt   = narrow ? CNT_NONE : i_cnt;
  end

  // R5: no surviving pair is narrower than the minimum
  a_r5_no_narrow_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (o_cnt == CNT_TWO) |-> ({1'b0, o_off1 - o_off0} >= MINV));
  // R7: filtering never changes the parity of the edge count
  a_r7_parity_kept: assert property (@(posedge clk) disable iff (!rst_n)
    o_cnt[0] == i_cnt[0]);
endmodule

// File: rtl/ted_out_conv.sv
module ted_out_conv
  import ted_pkg::*;
#(
  parameter int W       = 4,
  parameter int MINW    = 4,
  parameter bit FILT_EN = 1'b1,
  parameter int SAMPLE  = SAMPLE_NOW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ei_valid,
  input  logic          ei_start,
  input  edge_cnt_t     ei_cnt,
  input  logic [W-1:0]  ei_off0,
  input  logic [W-1:0]  ei_off1,
  output logic          ef_start,
  output edge_cnt_t     ef_cnt,
  output logic [W-1:0]  ef_off0,
  output logic [W-1:0]  ef_off1,
  output logic          out_bit
);
  logic lvl_q;
  logic fin;
  logic now_lvl;

  generate
    if (FILT_EN) begin : g_filt
      ted_pulse_filter #(.W(W), .MINW(MINW)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .i_start(ei_start), .i_cnt(ei_cnt), .i_off0(ei_off0), .i_off1(ei_off1),
        .o_start(ef_start), .o_cnt(ef_cnt), .o_off0(ef_off0), .o_off1(ef_off1)
      );
    end else begin : g_pass
      assign ef_start = ei_start;
      assign ef_cnt   = ei_cnt;
      assign ef_off0  = ei_off0;
      assign ef_off1  = ei_off1;
    end
  endgenerate

  assign fin     = final_level(ef_start, ef_cnt);
  assign now_lvl = ei_valid ? fin : lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else lvl_q <= now_lvl;
  end

  generate
    if (SAMPLE == SAMPLE_FALL) begin : g_fall
      logic fall_q;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else fall_q <= now_lvl;
      end
      assign out_bit = fall_q;
    end else if (SAMPLE == SAMPLE_RISE) begin : g_rise
      assign out_bit = lvl_q;
    end else begin : g_now
      assign out_bit = now_lvl;
    end
  endgenerate

  // R11: the held level does not move without a valid word
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ei_valid |=> $stable(lvl_q));
  // R7: a valid word with an even filtered count keeps the level
  a_r7_even_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_valid && !ef_cnt[0]) |=> lvl_q == $past(ef_start));
endmodule

// File: rtl/ted_boundary.sv
module ted_boundary
  import ted_pkg::*;
#(
  parameter int W       = 4,
  parameter int MINW    = 4,
  parameter bit FILT_EN = 1'b1,
  parameter int SAMPLE  = SAMPLE_NOW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_bit,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          eo_valid,
  input  logic          eo_ready,
  output logic          eo_start,
  output logic [1:0]    eo_cnt,
  output logic [W-1:0]  eo_off0,
  output logic [W-1:0]  eo_off1,
  input  logic          ei_valid,
  input  logic          ei_start,
  input  logic [1:0]    ei_cnt,
  input  logic [W-1:0]  ei_off0,
  input  logic [W-1:0]  ei_off1,
  output logic          ef_start,
  output logic [1:0]    ef_cnt,
  output logic [W-1:0]  ef_off0,
  output logic [W-1:0]  ef_off1,
  output logic          out_bit
);
  ted_in_conv #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .in_bit(in_bit), .in_valid(in_valid), .in_ready(in_ready),
    .eo_valid(eo_valid), .eo_ready(eo_ready),
    .eo_start(eo_start), .eo_cnt(eo_cnt), .eo_off0(eo_off0), .eo_off1(eo_off1)
  );

  ted_out_conv #(.W(W), .MINW(MINW), .FILT_EN(FILT_EN), .SAMPLE(SAMPLE)) u_out (
    .clk(clk), .rst_n(rst_n),
    .ei_valid(ei_valid), .ei_start(ei_start), .ei_cnt(ei_cnt),
    .ei_off0(ei_off0), .ei_off1(ei_off1),
    .ef_start(ef_start), .ef_cnt(ef_cnt), .ef_off0(ef_off0), .ef_off1(ef_off1),
    .out_bit(out_bit)
  );

  // R4: ready and valid pass straight through the input side
  a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == eo_ready) && (eo_valid == in_valid));
endmodule

// File: tb/sim_ted_boundary.sv
module sim_ted_boundary;
  localparam int W    = 4;
  localparam int MINW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_bit = 1'b0, in_valid = 1'b0, eo_ready = 1'b0;
  logic ei_valid = 1'b0, ei_start = 1'b0;
  logic [1:0] ei_cnt = 2'd0;
  logic [W-1:0] ei_off0 = '0, ei_off1 = '0;

  logic in_ready, eo_valid, eo_start;
  logic [1:0] eo_cnt;
  logic [W-1:0] eo_off0, eo_off1;
  logic ef_start [3];
  logic [1:0] ef_cnt [3];
  logic [W-1:0] ef_off0 [3], ef_off1 [3];
  logic obit [3];
  logic in_ready1, eo_valid1, eo_start1, in_ready2, eo_valid2, eo_start2;
  logic [1:0] eo_cnt1, eo_cnt2;
  logic [W-1:0] eo_o01, eo_o11, eo_o02, eo_o12;

  int errors = 0;
  int checks = 0;
  logic prev_m = 1'b0;
  logic lvl_m = 1'b0;

  always #4 clk = ~clk;

  ted_boundary #(.W(W), .MINW(MINW), .FILT_EN(1'b1), .SAMPLE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid), .in_ready(in_ready),
    .eo_valid(eo_valid), .eo_ready(eo_ready), .eo_start(eo_start), .eo_cnt(eo_cnt),
    .eo_off0(eo_off0), .eo_off1(eo_off1), .ei_valid(ei_valid), .ei_start(ei_start),
    .ei_cnt(ei_cnt), .ei_off0(ei_off0), .ei_off1(ei_off1), .ef_start(ef_start[0]),
    .ef_cnt(ef_cnt[0]), .ef_off0(ef_off0[0]), .ef_off1(ef_off1[0]), .out_bit(obit[0]));

  ted_boundary #(.W(W), .MINW(MINW), .FILT_EN(1'b1), .SAMPLE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid), .in_ready(in_ready1),
    .eo_valid(eo_valid1), .eo_ready(eo_ready), .eo_start(eo_start1), .eo_cnt(eo_cnt1),
    .eo_off0(eo_o01), .eo_off1(eo_o11), .ei_valid(ei_valid), .ei_start(ei_start),
    .ei_cnt(ei_cnt), .ei_off0(ei_off0), .ei_off1(ei_off1), .ef_start(ef_start[1]),
    .ef_cnt(ef_cnt[1]), .ef_off0(ef_off0[1]), .ef_off1(ef_off1[1]), .out_bit(obit[1]));

  ted_boundary #(.W(W), .MINW(MINW), .FILT_EN(1'b1), .SAMPLE(2)) u2 (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid), .in_ready(in_ready2),
    .eo_valid(eo_valid2), .eo_ready(eo_ready), .eo_start(eo_start2), .eo_cnt(eo_cnt2),
    .eo_off0(eo_o02), .eo_off1(eo_o12), .ei_valid(ei_valid), .ei_start(ei_start),
    .ei_cnt(ei_cnt), .ei_off0(ei_off0), .ei_off1(ei_off1), .ef_start(ef_start[2]),
    .ef_cnt(ef_cnt[2]), .ef_off0(ef_off0[2]), .ef_off1(ef_off1[2]), .out_bit(obit[2]));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_fcnt(input logic [1:0] c, input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    logic [W-1:0] g;
    g = b - a;
    if (c == 2'd2 && int'(g) < MINW) return 2'd0;
    return c;
  endfunction

  // One cycle: drive after the rising edge, check before the next one, then advance the model
  task automatic step(input logic ib, input logic iv, input logic er, input logic ev,
                      input logic es, input logic [1:0] ec, input logic [W-1:0] a,
                      input logic [W-1:0] b);
    logic [1:0] fc;
    logic fin, nowl;
    @(posedge clk);
    #1;
    in_bit = ib; in_valid = iv; eo_ready = er;
    ei_valid = ev; ei_start = es; ei_cnt = ec; ei_off0 = a; ei_off1 = b;
    #5;
    chk("R4 in_ready", int'(in_ready), int'(er));
    chk("R4 eo_valid", int'(eo_valid), int'(iv));
    chk("R2/R3 eo_start", int'(eo_start), int'(prev_m));
    chk("R2/R3 eo_cnt", int'(eo_cnt), (ib != prev_m) ? 1 : 0);
    chk("R2 offsets zero", int'(eo_off0) + int'(eo_off1), 0);
    fc = exp_fcnt(ec, a, b);
    fin = es ^ fc[0];
    nowl = ev ? fin : lvl_m;
    for (int k = 0; k < 3; k++) begin
      chk((fc != ec) ? "R5 narrow pair cnt" : "R6 pass cnt", int'(ef_cnt[k]), int'(fc));
      chk("R6 start/offsets", {int'(ef_start[k]), int'(ef_off0[k]), int'(ef_off1[k])} == {int'(es), int'(a), int'(b)} ? 1 : 0, 1);
    end
    chk(ev ? "R8 R7 mode0 level" : "R11 mode0 hold", int'(obit[0]), int'(nowl));
    chk("R9 mode1 falling", int'(obit[1]), int'(nowl));
    chk("R10 mode2 previous", int'(obit[2]), int'(lvl_m));
    if (iv && er) prev_m = ib;
    lvl_m = nowl;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    #1 chk("R1 reset out mode0", int'(obit[0]), 0);
    chk("R1 reset out mode2", int'(obit[2]), 0);
    chk("R1 reset eo_start", int'(eo_start), 0);
    rst_n = 1'b1;
    // R1: steady low right after reset
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0);
    // R2: rising input gives one edge at zero
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'd3, 4'd3);
    // R3: steady high
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 4'd0);
    // R4: stall keeps the word, then release
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0);
    // R5: zero-width pair, pair just below, pair at the minimum (R6)
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 4'd7, 4'd7);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 4'd2, 4'd5);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 4'd2, 4'd6);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'd9, 4'd9);
    // R11: idle with a word that would change the level
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0);
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      logic [1:0] c;
      a = W'($urandom_range(0, 15));
      b = W'($urandom_range(int'(a), 15));
      c = 2'($urandom_range(0, 2));
      if (c == 2'd0) begin a = '0; b = '0; end
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)), c, a, b);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule